// File: doc/BRIEF.md
# Two-Cycle DMA Transfer Sequencer

This block is a single-channel DMA engine. It moves one data word per transfer between a peripheral FIFO and memory. Every transfer is a bus read followed at once by a bus write. The read data is kept in a holding register between the two cycles. Each bus cycle spans four clocks, T1 to T4. The strobe is high in T2 and T3 only.

The block has two modes. In the to-memory mode, the peripheral holds its request high when it has data. The block reads the FIFO and writes the word to memory. In the from-memory mode, the peripheral raises its request when it wants data. The block reads memory and writes the word into the peripheral. That write is what clears the request.

Software arms the channel with a start address and a transfer count. The channel then runs until the count is used up, and raises a done flag.

Top module: `dma_pair_sequencer`

## Requirements
- R1: With `cfg_to_mem`=1, a transfer reads with `bus_periph`=1 and then writes with `bus_periph`=0. With `cfg_to_mem`=0, it reads with `bus_periph`=0 and then writes with `bus_periph`=1. The mode is sampled when a transfer starts.
- R2: A transfer starts from idle whenever all of these hold: `dma_req` is high, `cfg_enable` is high, and the remaining count is non-zero with done clear. The start depends on the level of `dma_req`, not on an edge, so a request held high gives back-to-back transfers.
- R3: Each bus cycle is four clocks. The strobe is low in T1, high for exactly two clocks (T2, T3) and low in T4. The write cycle directly follows the read cycle.
- R4: The word on `bus_rdata` at the end of read T3 is driven on `bus_wdata` for the whole write cycle. It does not change while `bus_wr` is high.
- R5: `bus_rd` and `bus_wr` are never high in the same clock. `bus_addr` holds one value while either strobe is high.
- R6: Memory accesses use the armed address, which advances by one after each memory access. Peripheral accesses drive `bus_addr`=0.
- R7: After each write cycle, the remaining count decreases by one. When it reaches zero, `done` goes to 1.
  - While `done`=1, requests produce no strobes.
  - A `cfg_arm` pulse in idle loads the address and count and clears `done`.
  - Arming with a count of 0 sets `done` at once.
  - A `cfg_arm` pulse during a transfer is ignored.
- R8: After a from-memory transfer, no new transfer starts while `dma_req` stays high. `dma_req` must first be seen low at least once.
- R9: While `cfg_enable`=0, no transfer starts, whatever the state of `dma_req`.
- R10: Synchronous reset (`rst`=1 at a clock edge) has these effects by the next clock:
  - both strobes are low;
  - `done`=0;
  - the sequencer is idle and any transfer in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Channel enable, sampled at transfer start |
| cfg_to_mem | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| cfg_arm | input | 1 | One-clock pulse that loads address and count |
| cfg_addr | input | AW | Start memory address |
| cfg_count | input | CW | Number of transfers |
| dma_req | input | 1 | Level-sensitive request from the peripheral |
| bus_rdata | input | DW | Read data from memory or peripheral |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_periph | output | 1 | 1: the current cycle targets the peripheral FIFO |
| bus_addr | output | AW | Memory address, 0 for peripheral cycles |
| bus_wdata | output | DW | Write data from the holding register |
| done | output | 1 | Count exhausted |

## Verification
The bench builds the block with AW=8, DW=16 and CW=4. A count of two or three then reaches `done` within a few dozen clocks. This puts the exhausted-count, re-arm and zero-count paths within easy reach. The 8-bit address lets the bench model the whole memory, so each write is checked against the address the bench predicts. A 16-bit word is wide enough for every peripheral and memory value to be unique.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_state_e;

  localparam logic [1:0] PH_T1 = 2'd0;
  localparam logic [1:0] PH_T2 = 2'd1;
  localparam logic [1:0] PH_T3 = 2'd2;
  localparam logic [1:0] PH_T4 = 2'd3;

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       to_mem,
  input  logic       dreq,
  input  logic       count_nz,
  output seq_state_e state_q,
  output logic [1:0] phase_q,
  output seq_state_e nxt_state,
  output logic [1:0] nxt_phase,
  output logic       nxt_mode,
  output logic       mode_q
);

  logic start;
  logic need_low_q;
  logic guard_ok;

  // A request still high after a from-memory transfer must drop first
  always_comb guard_ok = to_mem || !need_low_q;

  always_comb begin
    nxt_state = state_q;
    nxt_phase = phase_q;
    start     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (enable && count_nz && dreq && guard_ok) begin
          start     = 1'b1;
          nxt_state = ST_RD;
          nxt_phase = PH_T1;
        end
      end
      ST_RD: begin
        if (phase_q == PH_T4) begin
          nxt_state = ST_WR;
          nxt_phase = PH_T1;
        end else begin
          nxt_phase = phase_q + 2'd1;
        end
      end
      ST_WR: begin
        if (phase_q == PH_T4) begin
          nxt_state = ST_IDLE;
          nxt_phase = PH_T1;
        end else begin
          nxt_phase = phase_q + 2'd1;
        end
      end
      default: begin
        nxt_state = ST_IDLE;
        nxt_phase = PH_T1;
      end
    endcase
  end

  always_comb nxt_mode = start ? to_mem : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      phase_q    <= PH_T1;
      mode_q     <= 1'b0;
      need_low_q <= 1'b0;
    end else begin
      state_q <= nxt_state;
      phase_q <= nxt_phase;
      if (start) mode_q <= to_mem;
      if (state_q == ST_WR && phase_q == PH_T4 && !mode_q && dreq)
        need_low_q <= 1'b1;
      else if (!dreq)
        need_low_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_seq_regs.sv
module dma_seq_regs #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          idle,
  input  logic [AW-1:0] arm_addr,
  input  logic [CW-1:0] arm_count,
  input  logic          mem_step,
  input  logic          pair_done,
  output logic [AW-1:0] mem_addr,
  output logic          count_nz,
  output logic          done
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [CW-1:0] count_q;

  always_comb count_nz = (count_q != '0) && !done;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      count_q  <= '0;
      done     <= 1'b0;
    end else if (arm && idle) begin
      mem_addr <= arm_addr;
      count_q  <= arm_count;
      done     <= (arm_count == '0);
    end else begin
      if (mem_step) mem_addr <= mem_addr + AW'(1);
      if (pair_done) begin
        count_q <= count_q - CNT_ONE;
        if (count_q == CNT_ONE) done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_seq_buspath.sv
module dma_seq_buspath
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_e    nxt_state,
  input  logic [1:0]    nxt_phase,
  input  logic          nxt_mode,
  input  logic          capture,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_periph,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata
);

  logic [DW-1:0] hold_q;
  logic          strobe_ph;
  logic          periph_nxt;

  always_comb strobe_ph  = (nxt_phase == PH_T2) || (nxt_phase == PH_T3);
  always_comb periph_nxt = (nxt_state == ST_RD &&  nxt_mode) ||
                           (nxt_state == ST_WR && !nxt_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd     <= 1'b0;
      bus_wr     <= 1'b0;
      bus_periph <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      hold_q     <= '0;
    end else begin
      bus_rd <= (nxt_state == ST_RD) && strobe_ph;
      bus_wr <= (nxt_state == ST_WR) && strobe_ph;
      if (nxt_state == ST_IDLE) begin
        bus_periph <= 1'b0;
        bus_addr   <= '0;
      end else if (nxt_phase == PH_T1) begin
        bus_periph <= periph_nxt;
        bus_addr   <= periph_nxt ? '0 : mem_addr;
      end
      bus_wdata <= (nxt_state == ST_WR) ? hold_q : '0;
      if (capture) hold_q <= bus_rdata;
    end
  end

endmodule

// File: rtl/dma_pair_sequencer.sv
module dma_pair_sequencer
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_enable,
  input  logic          cfg_to_mem,
  input  logic          cfg_arm,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic          dma_req,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_periph,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          done
);

  seq_state_e    state_q;
  seq_state_e    nxt_state;
  logic [1:0]    phase_q;
  logic [1:0]    nxt_phase;
  logic          nxt_mode;
  logic          mode_q;
  logic          count_nz;
  logic [AW-1:0] mem_addr;
  logic          capture;
  logic          pair_done;
  logic          mem_step;
  logic          idle;

  always_comb begin
    idle      = (state_q == ST_IDLE);
    capture   = (state_q == ST_RD) && (phase_q == PH_T3);
    pair_done = (state_q == ST_WR) && (phase_q == PH_T4);
    mem_step  = ((state_q == ST_RD) && (phase_q == PH_T4) && !mode_q) ||
                ((state_q == ST_WR) && (phase_q == PH_T4) &&  mode_q);
  end

  dma_seq_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .enable    (cfg_enable),
    .to_mem    (cfg_to_mem),
    .dreq      (dma_req),
    .count_nz  (count_nz),
    .state_q   (state_q),
    .phase_q   (phase_q),
    .nxt_state (nxt_state),
    .nxt_phase (nxt_phase),
    .nxt_mode  (nxt_mode),
    .mode_q    (mode_q)
  );

  dma_seq_regs #(.AW(AW), .CW(CW)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .arm       (cfg_arm),
    .idle      (idle),
    .arm_addr  (cfg_addr),
    .arm_count (cfg_count),
    .mem_step  (mem_step),
    .pair_done (pair_done),
    .mem_addr  (mem_addr),
    .count_nz  (count_nz),
    .done      (done)
  );

  dma_seq_buspath #(.AW(AW), .DW(DW)) bus_i (
    .clk        (clk),
    .rst        (rst),
    .nxt_state  (nxt_state),
    .nxt_phase  (nxt_phase),
    .nxt_mode   (nxt_mode),
    .capture    (capture),
    .mem_addr   (mem_addr),
    .bus_rdata  (bus_rdata),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_periph (bus_periph),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata)
  );

endmodule

// File: rtl/dma_pair_sequencer_chk.sv
module dma_pair_sequencer_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr)); // R5

  AST_RD_MIN_TWO: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd) |=> bus_rd); // R3

  AST_RD_MAX_TWO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && $past(bus_rd)) |=> !bus_rd); // R3

  AST_WR_MIN_TWO: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr) |=> bus_wr); // R3

  AST_WR_MAX_TWO: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && $past(bus_wr)) |=> !bus_wr); // R3

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> $stable(bus_addr)); // R5

  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> $stable(bus_wdata)); // R4

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_rd && !bus_wr)); // R7

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (!bus_rd && !bus_wr && !done)); // R10

endmodule

bind dma_pair_sequencer dma_pair_sequencer_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/dma_pair_sequencer_tb_top.sv
module dma_pair_sequencer_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 4;

  typedef struct packed {
    logic          periph;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_enable = 1'b0;
  logic          cfg_to_mem = 1'b0;
  logic          cfg_arm = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic          dma_req = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rd, bus_wr, bus_periph, done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;

  exp_t          exp_q[$];
  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] src_idx = '0;
  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int wd_fail = 0;
  int rd_cnt = 0, wr_cnt = 0, pwr_cnt = 0;

  always #2 clk = ~clk;

  dma_pair_sequencer #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_to_mem(cfg_to_mem),
    .cfg_arm(cfg_arm), .cfg_addr(cfg_addr), .cfg_count(cfg_count),
    .dma_req(dma_req), .bus_rdata(bus_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_periph(bus_periph), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .done(done)
  );

  function automatic logic [DW-1:0] seed(input logic [AW-1:0] a);
    return DW'(16'h5000 + 16'(a) * 16'd3);
  endfunction

  always_comb bus_rdata = bus_periph ? (DW'(16'hA000) + src_idx) : mem[bus_addr];

  // Monitor: pulse widths and scoreboard of write cycles
  logic rd_prev = 1'b0, wr_prev = 1'b0;
  int   rd_len = 0, wr_len = 0;
  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] = seed(AW'(i));
      rd_prev = 1'b0; wr_prev = 1'b0; rd_len = 0; wr_len = 0;
    end else begin
      if (bus_rd) rd_len++;
      else if (rd_prev) begin
        mon_checks++;
        if (rd_len != 2) begin
          mon_fails++;
          $display("FAIL R3 read strobe width act=%0d exp=2", rd_len);
        end
        rd_len = 0;
        rd_cnt++;
        if (bus_periph) src_idx = src_idx + 1'b1;
      end
      if (bus_wr && !wr_prev) begin
        mon_checks++;
        if (exp_q.size() == 0) begin
          mon_fails++;
          $display("FAIL R2 unexpected write act=addr %0h data %0h exp=none", bus_addr, bus_wdata);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (bus_periph != e.periph || bus_addr != e.addr || bus_wdata != e.data) begin
            mon_fails++;
            $display("FAIL R1/R4/R6 write act=p%0d a%0h d%0h exp=p%0d a%0h d%0h",
                     bus_periph, bus_addr, bus_wdata, e.periph, e.addr, e.data);
          end
        end
        if (!bus_periph) mem[bus_addr] = bus_wdata;
        else pwr_cnt++;
        wr_cnt++;
      end
      if (bus_wr) wr_len++;
      else if (wr_prev) begin
        mon_checks++;
        if (wr_len != 2) begin
          mon_fails++;
          $display("FAIL R3 write strobe width act=%0d exp=2", wr_len);
        end
        wr_len = 0;
      end
      rd_prev = bus_rd;
      wr_prev = bus_wr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic arm(input logic [AW-1:0] a, input logic [CW-1:0] n);
    @(negedge clk);
    cfg_addr = a; cfg_count = n; cfg_arm = 1'b1;
    @(negedge clk);
    cfg_arm = 1'b0;
  endtask

  task automatic push_src(input logic [AW-1:0] a, input int n);
    for (int i = 0; i < n; i++)
      exp_q.push_back('{periph: 1'b0, addr: a + AW'(i), data: DW'(16'hA000) + src_idx + DW'(i)});
  endtask

  task automatic push_tgt(input logic [AW-1:0] a);
    exp_q.push_back('{periph: 1'b1, addr: '0, data: seed(a)});
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + mon_checks + wd_fail, fails + mon_fails + wd_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
  end

  initial begin
    int r0, w0, p0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_rd && !bus_wr && !done, "R10 reset state", {bus_rd, bus_wr, done}, 0);

    // Source mode, back-to-back on a held level
    cfg_enable = 1'b1; cfg_to_mem = 1'b1;
    arm(8'h10, 4'd3);
    push_src(8'h10, 3);
    r0 = rd_cnt; w0 = wr_cnt;
    dma_req = 1'b1;
    wait (wr_cnt == w0 + 3);
    repeat (10) @(negedge clk);
    chk(done == 1'b1, "R7 done after count", done, 1);
    repeat (20) @(negedge clk);
    chk(rd_cnt == r0 + 3, "R7 requests ignored when done", rd_cnt - r0, 3);
    dma_req = 1'b0;

    // Target mode, request cleared by the peripheral write
    cfg_to_mem = 1'b0;
    arm(8'h40, 4'd3);
    for (int i = 0; i < 3; i++) begin
      p0 = pwr_cnt;
      push_tgt(8'h40 + AW'(i));
      @(negedge clk) dma_req = 1'b1;
      wait (pwr_cnt == p0 + 1);
      @(negedge clk) dma_req = 1'b0;
      @(negedge clk);
    end
    repeat (10) @(negedge clk);
    chk(done == 1'b1, "R1 target mode done", done, 1);

    // Target mode with a stale request held high
    arm(8'h50, 4'd2);
    p0 = pwr_cnt;
    push_tgt(8'h50);
    dma_req = 1'b1;
    repeat (60) @(negedge clk);
    chk(pwr_cnt == p0 + 1, "R8 stale request blocked", pwr_cnt - p0, 1);
    push_tgt(8'h51);
    dma_req = 1'b0;
    @(negedge clk);
    @(negedge clk) dma_req = 1'b1;
    wait (pwr_cnt == p0 + 2);
    repeat (12) @(negedge clk);
    dma_req = 1'b0;
    chk(pwr_cnt == p0 + 2 && done, "R8 resume after low", pwr_cnt - p0, 2);

    // Arm during a transfer is ignored
    cfg_to_mem = 1'b1;
    arm(8'h20, 4'd2);
    push_src(8'h20, 2);
    r0 = rd_cnt; w0 = wr_cnt;
    dma_req = 1'b1;
    wait (bus_rd == 1'b1);
    arm(8'h70, 4'd5);
    wait (wr_cnt == w0 + 2);
    repeat (30) @(negedge clk);
    chk(rd_cnt == r0 + 2 && done, "R7 arm ignored while busy", rd_cnt - r0, 2);
    dma_req = 1'b0;

    // Disabled channel
    cfg_enable = 1'b0;
    arm(8'h30, 4'd2);
    r0 = rd_cnt; w0 = wr_cnt;
    dma_req = 1'b1;
    repeat (30) @(negedge clk);
    chk(rd_cnt == r0, "R9 disabled ignores request", rd_cnt - r0, 0);
    push_src(8'h30, 2);
    cfg_enable = 1'b1;
    wait (wr_cnt == w0 + 2);
    repeat (10) @(negedge clk);
    dma_req = 1'b0;
    chk(done == 1'b1, "R2 enable starts transfers", done, 1);

    // Reset in the middle of a read
    arm(8'h34, 4'd2);
    dma_req = 1'b1;
    wait (bus_rd == 1'b1);
    @(negedge clk) rst = 1'b1;
    dma_req = 1'b0;
    @(negedge clk);
    chk(!bus_rd && !bus_wr && !done, "R10 reset mid transfer", {bus_rd, bus_wr, done}, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(!bus_rd && !bus_wr, "R10 stays idle after reset", {bus_rd, bus_wr}, 0);

    // Zero count
    arm(8'h00, 4'd0);
    chk(done == 1'b1, "R7 zero count sets done", done, 1);
    r0 = rd_cnt;
    dma_req = 1'b1;
    repeat (20) @(negedge clk);
    dma_req = 1'b0;
    chk(rd_cnt == r0, "R7 zero count no transfer", rd_cnt - r0, 0);

    chk(exp_q.size() == 0, "R1 all expected writes seen", exp_q.size(), 0);
    summary();
  end

endmodule